// File: doc/BRIEF.md
# Rank Select Search with Spare Substitution

This block resolves which chip-select (rank) on a memory channel owns a channel-normalized address. A search is launched with a one-cycle `start`. The block captures the address and the channel number, picks the base/mask table of the controller serving that channel, and walks the eight chip-select entries in ascending order. It tests one entry per clock and stops at the first enabled entry whose unmasked bits agree with the address.

When the channel has completed an online-spare swap and the matching rank is the rank recorded as failed, a second walk picks out the lowest entry carrying the spare flag. The result then names that spare rank instead. The outcome is a `found` flag, a 3-bit chip-select and the DIMM index derived from it. These are presented with a one-cycle `done` pulse. The tables and the spare-control word are expected to stay static while a search runs.

The controller is a four-state machine:
- `ST_IDLE` waits. On `start` it takes the transition *accept* to `ST_SCAN`.
- `ST_SCAN` tests entry `idx`. On an ordinary hit it takes *hit* to `ST_DONE`. On a hit on the failed rank of a swapped channel it takes *redirect* to `ST_SPARE`. After the last entry with no hit it takes *exhaust* to `ST_DONE`. Otherwise it takes *step* and stays in `ST_SCAN`.
- `ST_SPARE` tests the spare flag of entry `idx`. It takes *spare_hit* or *spare_exhaust* to `ST_DONE`, or *spare_step* and stays.
- `ST_DONE` raises `done` and takes *retire* back to `ST_IDLE`.

Top module: `csm_rank_match`

## Requirements
- R1: After reset, `done`, `found`, `cs` and `dimm` are all 0.
- R2: An entry matches only when its bit 0 (enable) is 1. The address is shifted right by 8. The shifted address, the base entry and the mask entry are each ANDed with `reg_mask`. The entry matches when the shifted address and the base agree on every bit where the masked mask entry is 0.
- R3: Entries are tested in ascending order 0 to 7, and the lowest matching entry is reported.
- R4: Mask entry `n` of a controller serves both chip-selects 2n and 2n+1.
- R5: When `ganged` is 0, the tables of controller `chan_sel` are used. When `ganged` is 1, the tables of controller 0 are used whatever `chan_sel` is.
- R6: For channel c, bit 1+2c of `spare_ctl` is the swap-done flag and bits 4+4c to 6+4c hold the failed rank. If the flag is set and the matched entry equals the failed rank, the reported chip-select is the lowest entry whose bit 1 (spare) is 1.
- R7: The matched chip-select is reported unchanged when the swap-done flag is clear, when the match is not the failed rank, or when no entry carries the spare flag.
- R8: If no enabled entry matches, `done` pulses with `found` = 0.
- R9: `done` is high for exactly one cycle. It is first seen k+2 rising edges after the edge that samples `start`, counting that edge, for a direct match at entry k. It is seen after 9 edges for a miss, after k+3+s edges for a redirect to spare entry s, and after k+10 edges for a redirect that finds no spare.
- R10: `dimm` equals `cs` shifted right by one.
- R11: `start` has no effect while a search is in progress. `found`, `cs` and `dimm` hold their values while idle until a new search is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a search (accepted only when idle) |
| chan_addr | input | ADDR_W (40) | Channel-normalized address |
| chan_sel | input | CH_W (1) | Channel number |
| ganged | input | 1 | Use controller 0 tables regardless of channel |
| reg_mask | input | REG_W (32) | Global mask applied to address, base and mask |
| base_tbl | input | NUM_CTRL*NUM_CS*REG_W (512) | Base entries, entry (ctl*NUM_CS+cs) at bits REG_W*(ctl*NUM_CS+cs) |
| mask_tbl | input | NUM_CTRL*NUM_CS/2*REG_W (256) | Mask entries, one per chip-select pair |
| spare_ctl | input | SPC_W (32) | Per-channel swap-done flags and failed-rank fields |
| done | output | 1 | One-cycle result strobe |
| found | output | 1 | A chip-select matched |
| cs | output | 3 | Reported chip-select |
| dimm | output | 2 | DIMM index (cs / 2) |

## Verification
Several address patterns are searched:
- Exact matches at low and high entries, where the measured latency shows that one entry is tested per cycle.
- An address claimed by two entries, which shows that the lowest entry wins.
- A disabled entry and a global mask that hides the high address bits, which separate the enable bit and `reg_mask` from the plain compare.
- A widened pair mask with one of its two ranks disabled, which shows that both ranks of a pair read the same mask entry.

The controller-select cases search the same address on channel 1 with `ganged` low and then high, so the two tables give different ranks. The spare cases cover four situations: the failed rank on a swapped channel, another rank on that channel, the same rank on a channel without a swap, and a swap with no spare flagged. Each of these yields a different chip-select or latency. A second `start` pulse during a search, followed by idle cycles with new inputs, shows that the result is neither disturbed nor lost.

// File: rtl/csm_pkg.sv
package csm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_SPARE = 2'd2,
        ST_DONE  = 2'd3
    } csm_state_e;

endpackage

// File: rtl/csm_entry_cmp.sv
module csm_entry_cmp #(
    parameter int REG_W = 32
) (
    input  logic [REG_W-1:0] addr_sh,
    input  logic [REG_W-1:0] base,
    input  logic [REG_W-1:0] mask,
    input  logic [REG_W-1:0] reg_mask,
    output logic             hit,
    output logic             spare_flag
);

    logic [REG_W-1:0] care;
    logic [REG_W-1:0] diff;

    always_comb begin
        care       = reg_mask & ~(mask & reg_mask);
        diff       = (addr_sh & reg_mask) ^ (base & reg_mask);
        hit        = base[0] && ((diff & care) == '0);
        spare_flag = base[1];
    end

endmodule

// File: rtl/csm_spare_sel.sv
module csm_spare_sel #(
    parameter int NUM_CH = 2,
    parameter int SPC_W  = 32,
    parameter int CS_W   = 3
) (
    input  logic [SPC_W-1:0]          spare_ctl,
    input  logic [$clog2(NUM_CH)-1:0] chan,
    output logic                      swap_done,
    output logic [CS_W-1:0]           bad_cs
);

    logic            swp [NUM_CH];
    logic [CS_W-1:0] bad [NUM_CH];
    logic            unused_spc;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign swp[c] = spare_ctl[1 + 2*c];
        assign bad[c] = spare_ctl[4 + 4*c +: CS_W];
    end

    assign unused_spc = ^spare_ctl;
    assign swap_done  = swp[chan];
    assign bad_cs     = bad[chan];

endmodule

// File: rtl/csm_rank_match.sv
module csm_rank_match
    import csm_pkg::*;
#(
    parameter int ADDR_W    = 40,
    parameter int REG_W     = 32,
    parameter int CMP_SHIFT = 8,
    parameter int NUM_CS    = 8,
    parameter int NUM_CTRL  = 2,
    parameter int SPC_W     = 32,
    parameter int CH_W      = $clog2(NUM_CTRL),
    parameter int CS_W      = $clog2(NUM_CS),
    parameter int MSK_N     = NUM_CS / 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            start,
    input  logic [ADDR_W-1:0]               chan_addr,
    input  logic [CH_W-1:0]                 chan_sel,
    input  logic                            ganged,
    input  logic [REG_W-1:0]                reg_mask,
    input  logic [NUM_CTRL*NUM_CS*REG_W-1:0] base_tbl,
    input  logic [NUM_CTRL*MSK_N*REG_W-1:0]  mask_tbl,
    input  logic [SPC_W-1:0]                spare_ctl,
    output logic                            done,
    output logic                            found,
    output logic [CS_W-1:0]                 cs,
    output logic [CS_W-2:0]                 dimm
);

    localparam logic [CS_W-1:0] LAST = CS_W'(NUM_CS - 1);

    csm_state_e       st, st_nxt;
    logic [REG_W-1:0] addr_q;
    logic [CH_W-1:0]  ctl_q;
    logic [CH_W-1:0]  ch_q;
    logic [CS_W-1:0]  idx_q;
    logic             unused_addr_lo;

    logic [REG_W-1:0] base_arr [NUM_CTRL][NUM_CS];
    logic [REG_W-1:0] mask_arr [NUM_CTRL][MSK_N];

    for (genvar c = 0; c < NUM_CTRL; c++) begin : g_ctl
        for (genvar e = 0; e < NUM_CS; e++) begin : g_base
            assign base_arr[c][e] = base_tbl[(c*NUM_CS + e)*REG_W +: REG_W];
        end
        for (genvar m = 0; m < MSK_N; m++) begin : g_mask
            assign mask_arr[c][m] = mask_tbl[(c*MSK_N + m)*REG_W +: REG_W];
        end
    end

    assign unused_addr_lo = ^chan_addr[CMP_SHIFT-1:0];

    logic [REG_W-1:0] cur_base, cur_mask;
    logic             hit, spare_flag;
    logic             swap_done;
    logic [CS_W-1:0]  bad_cs;
    logic             redirect;

    assign cur_base = base_arr[ctl_q][idx_q];
    assign cur_mask = mask_arr[ctl_q][idx_q[CS_W-1:1]];

    csm_entry_cmp #(.REG_W(REG_W)) u_cmp (
        .addr_sh   (addr_q),
        .base      (cur_base),
        .mask      (cur_mask),
        .reg_mask  (reg_mask),
        .hit       (hit),
        .spare_flag(spare_flag)
    );

    csm_spare_sel #(.NUM_CH(NUM_CTRL), .SPC_W(SPC_W), .CS_W(CS_W)) u_spare (
        .spare_ctl(spare_ctl),
        .chan     (ch_q),
        .swap_done(swap_done),
        .bad_cs   (bad_cs)
    );

    assign redirect = swap_done && (idx_q == bad_cs);

    // next-state decode
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE:  if (start) st_nxt = ST_SCAN;
            ST_SCAN: begin
                if (hit)                 st_nxt = redirect ? ST_SPARE : ST_DONE;
                else if (idx_q == LAST)  st_nxt = ST_DONE;
            end
            ST_SPARE: if (spare_flag || idx_q == LAST) st_nxt = ST_DONE;
            ST_DONE:  st_nxt = ST_IDLE;
            default:  st_nxt = ST_IDLE;
        endcase
    end

    // state register and search context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            addr_q <= '0;
            ctl_q  <= '0;
            ch_q   <= '0;
            idx_q  <= '0;
        end else begin
            st <= st_nxt;
            unique case (st)
                ST_IDLE: if (start) begin
                    addr_q <= chan_addr[CMP_SHIFT +: REG_W];
                    ctl_q  <= ganged ? '0 : chan_sel;
                    ch_q   <= chan_sel;
                    idx_q  <= '0;
                end
                ST_SCAN:  idx_q <= (hit && redirect) ? '0 : idx_q + 1'b1;
                ST_SPARE: idx_q <= idx_q + 1'b1;
                default:  idx_q <= idx_q;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done  <= 1'b0;
            found <= 1'b0;
            cs    <= '0;
        end else begin
            done <= (st_nxt == ST_DONE);
            if (st == ST_SCAN) begin
                if (hit) begin
                    found <= 1'b1;
                    cs    <= idx_q;
                end else if (idx_q == LAST) begin
                    found <= 1'b0;
                    cs    <= '0;
                end
            end else if (st == ST_SPARE && spare_flag) begin
                cs <= idx_q;
            end
        end
    end

    assign dimm = cs[CS_W-1:1];

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                   // R9
    AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && start) |=> (st == ST_SCAN));                     // R9
    AST_NO_SILENT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SCAN || st == ST_SPARE) |=> (st != ST_IDLE));            // R11
    AST_MISS_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SCAN && !hit && idx_q == LAST) |=> (done && !found));    // R8
    AST_SPARE_PICK: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SPARE && spare_flag) |=> (done && found && cs == $past(idx_q))); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !start) |=> ($stable(found) && $stable(cs)));    // R11

endmodule

// File: tb/test_csm_rank_match.sv
module test_csm_rank_match;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [39:0]  chan_addr = '0;
    logic         chan_sel = 1'b0;
    logic         ganged = 1'b0;
    logic [31:0]  reg_mask;
    logic [511:0] base_tbl;
    logic [255:0] mask_tbl;
    logic [31:0]  spare_ctl;
    logic         done, found;
    logic [2:0]   cs;
    logic [1:0]   dimm;

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;

    always #10 clk = ~clk;

    csm_rank_match i_csm_rank_match (
        .clk(clk), .rst_n(rst_n), .start(start), .chan_addr(chan_addr),
        .chan_sel(chan_sel), .ganged(ganged), .reg_mask(reg_mask),
        .base_tbl(base_tbl), .mask_tbl(mask_tbl), .spare_ctl(spare_ctl),
        .done(done), .found(found), .cs(cs), .dimm(dimm)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            nerr++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [39:0] adr(input int hi);
        return 40'(hi) << 28;
    endfunction

    task automatic set_base(input int ctl, input int e, input logic [31:0] v);
        base_tbl[(ctl*8 + e)*32 +: 32] = v;
    endtask

    task automatic init_tables;
        reg_mask  = 32'hFFFF_FFE0;
        spare_ctl = '0;
        for (int e = 0; e < 8; e++) begin
            set_base(0, e, (32'(e) << 20) | 32'h1);
            set_base(1, e, (32'(7 - e) << 20) | 32'h1);
        end
        for (int m = 0; m < 8; m++) mask_tbl[m*32 +: 32] = 32'h000F_FFE0;
    endtask

    task automatic run_search(input logic [39:0] a, input logic ch, input logic g,
                              input logic ef, input logic [2:0] ecs, input int elat,
                              input string tag);
        int n;
        n = 0;
        @(negedge clk);
        chan_addr = a; chan_sel = ch; ganged = g; start = 1'b1;
        do begin
            @(posedge clk); n++;
            @(negedge clk); start = 1'b0;
        end while (!done && n < 40);
        chk(n == elat, {tag, " R9 latency"}, 64'(n), 64'(elat));
        chk(found == ef, {tag, " found"}, 64'(found), 64'(ef));
        if (ef) begin
            chk(cs == ecs, {tag, " cs"}, 64'(cs), 64'(ecs));
            chk(dimm == ecs[2:1], {tag, " R10 dimm"}, 64'(dimm), 64'(ecs[2:1]));
        end
        @(negedge clk);
        chk(!done, {tag, " R9 done pulse"}, 64'(done), 64'd0);
    endtask

    task automatic t_reset;
        chk(done == 0 && found == 0 && cs == 0 && dimm == 0, "R1 reset outputs",
            64'({done, found, cs, dimm}), 64'd0);
    endtask

    task automatic t_basic;
        init_tables();
        run_search(adr(5) | 40'h123_4567, 1'b0, 1'b0, 1'b1, 3'd5, 7, "R2 exact match");
        run_search(adr(0), 1'b0, 1'b0, 1'b1, 3'd0, 2, "R2 entry 0");
        run_search(adr(7), 1'b0, 1'b0, 1'b1, 3'd7, 9, "R2 entry 7");
    endtask

    task automatic t_first_wins;
        init_tables();
        set_base(0, 1, (32'd3 << 20) | 32'h1);
        run_search(adr(3), 1'b0, 1'b0, 1'b1, 3'd1, 3, "R3 lowest match wins");
    endtask

    task automatic t_disabled;
        init_tables();
        set_base(0, 3, 32'd3 << 20);
        run_search(adr(3), 1'b0, 1'b0, 1'b0, 3'd0, 9, "R2 R8 disabled entry miss");
    endtask

    task automatic t_pair_mask;
        init_tables();
        mask_tbl[2*32 +: 32] = 32'h00FF_FFE0;
        run_search(adr(7), 1'b0, 1'b0, 1'b1, 3'd4, 6, "R4 pair mask cs4");
        set_base(0, 4, 32'd4 << 20);
        run_search(adr(7), 1'b0, 1'b0, 1'b1, 3'd5, 7, "R4 pair mask cs5");
    endtask

    task automatic t_reg_mask;
        init_tables();
        run_search(adr(12'hF02), 1'b0, 1'b0, 1'b0, 3'd0, 9, "R8 full reg mask miss");
        reg_mask = 32'h0FFF_FFE0;
        run_search(adr(12'hF02), 1'b0, 1'b0, 1'b1, 3'd2, 4, "R2 reg mask hides high bits");
    endtask

    task automatic t_ctrl;
        init_tables();
        run_search(adr(2), 1'b1, 1'b0, 1'b1, 3'd5, 7, "R5 controller 1 table");
        run_search(adr(2), 1'b1, 1'b1, 1'b1, 3'd2, 4, "R5 ganged uses controller 0");
    endtask

    task automatic t_remap;
        init_tables();
        spare_ctl = (32'd1 << 1) | (32'd5 << 4);
        set_base(0, 6, (32'd6 << 20) | 32'h3);
        run_search(adr(5), 1'b0, 1'b0, 1'b1, 3'd6, 14, "R6 failed rank to spare");
        run_search(adr(4), 1'b0, 1'b0, 1'b1, 3'd4, 6, "R7 other rank kept");
        run_search(adr(2), 1'b1, 1'b0, 1'b1, 3'd5, 7, "R7 channel without swap kept");
        spare_ctl = spare_ctl | (32'd1 << 3) | (32'd5 << 8);
        set_base(1, 0, (32'd7 << 20) | 32'h3);
        run_search(adr(2), 1'b1, 1'b0, 1'b1, 3'd0, 8, "R6 channel 1 spare");
    endtask

    task automatic t_no_spare;
        init_tables();
        spare_ctl = (32'd1 << 1) | (32'd5 << 4);
        run_search(adr(5), 1'b0, 1'b0, 1'b1, 3'd5, 15, "R7 no spare flagged");
    endtask

    task automatic t_busy;
        int n;
        init_tables();
        n = 0;
        @(negedge clk);
        chan_addr = adr(6); chan_sel = 0; ganged = 0; start = 1'b1;
        do begin
            @(posedge clk); n++;
            @(negedge clk);
            start = (n == 2);
            if (n == 2) chan_addr = adr(1);
        end while (!done && n < 40);
        start = 1'b0;
        chk(n == 8, "R11 busy start latency", 64'(n), 64'd8);
        chk(found && cs == 3'd6, "R11 busy start ignored", 64'(cs), 64'd6);
        chan_addr = adr(2);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(found && cs == 3'd6 && !done, "R11 idle hold", 64'(cs), 64'd6);
        end
    endtask

    initial begin
        init_tables();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_first_wins();
        t_disabled();
        t_pair_mask();
        t_reg_mask();
        t_ctrl();
        t_remap();
        t_no_spare();
        t_busy();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule